// File: doc/BRIEF.md
# Instruction Length Decoder

This block sits between an instruction fetch unit and a decoder. Fetch hands it a stream of 16-bit parcels, one per accepted handshake. The block finds where each instruction ends and presents each complete instruction on a 64-bit output. The first parcel is in the top bits. A two-bit tag gives the size. A valid/ready pair paces the output. An instruction that is still partial stays inside the block until its last parcel arrives.

The size comes from the 5-bit major opcode in the top of the first parcel, together with marker values in the operand fields. A 6-bit register field equal to 62, or a compact 5-bit register field equal to 30, means a 32-bit immediate follows the base encoding. Branch redirects empty the block through a synchronous flush input.

Top module: `instr_len_dec`

## Requirements
- R1: While reset is held and in the first cycle after it, out_valid_o is low and in_ready_o is high.
- R2: A first parcel whose major opcode (bits 15..11) is 0b01000 or above is a 16-bit instruction with tag 0. The exception is the 48-bit case in R6. The parcel appears in out_instr_o[63:48] and bits 47..0 are zero.
- R3: A first parcel with major opcode below 0b01000 starts a 32-bit base word W = {first parcel, second parcel}. With no long immediate (R4, R5), tag 1 is output with W in [63:32] and zeros in [31:0]. Majors 0 and 1 never take a long immediate.
- R4: For majors 2 to 7, the register field B is built as B[5:3] = W[14:12] and B[2:0] = W[26:24]. When B equals 62, the instruction is 64 bits long with tag 3. The two following parcels appear in [31:0], in arrival order.
- R5: For majors 2 to 7, the field C = W[11:6] equal to 62 also makes the instruction 64 bits long, tag 3, but only where C names a register. That is major 3 always, and majors 4 to 7 when W[23:22] is 00 or 11. Major 2, and majors 4 to 7 with W[23:22] of 01 or 10, stay 32 bits.
- R6: Major 0b01110 with h = {bits 1..0, bits 7..5} of the first parcel equal to 30 is 48 bits long with tag 2. The three parcels appear in [63:16] and [15:0] is zero.
- R7: out_valid_o rises only once every parcel of the head instruction is buffered. Instructions leave in arrival order with none lost or repeated.
- R8: While out_valid_o is high and out_ready_i is low, the output instruction and tag hold steady and stay valid, unless a flush occurs.
- R9: flush_i discards every buffered parcel in the same cycle. During that cycle in_ready_o and out_valid_o are low, so no parcel or instruction crosses. The cycle after, the block is empty.
- R10: The buffer holds DEPTH parcels (default 4). With the buffer full, in_ready_o is low and nothing is overwritten.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Synchronous discard of all buffered parcels |
| in_valid_i | input | 1 | Parcel offered |
| in_ready_o | output | 1 | Parcel can be taken |
| in_parcel_i | input | 16 | Incoming instruction parcel |
| out_valid_o | output | 1 | Complete instruction present |
| out_ready_i | input | 1 | Consumer takes the instruction |
| out_instr_o | output | 64 | Instruction, first parcel in the top bits, unused low bits zero |
| out_len_o | output | 2 | Size tag: 0=16, 1=32, 2=48, 3=64 bits |

## Verification
A wrong size decode shows up at the very next delivery. The output carries too few or too many parcels. Every instruction after that one is misaligned, so a single length error corrupts the entire rest of the output stream. A wrong fill count shows as an early valid on a partial instruction, as a stalled stream, or as a lost or duplicated instruction. These appear within the handful of cycles that the buffer takes to fill or drain. A flush that leaves stale state shows as a stray instruction on the first delivery after the flush.

// File: rtl/ild_pkg.sv
package ild_pkg;
  localparam int PARCEL_W  = 16;
  localparam int INSTR_W   = 64;
  localparam int MAX_PARC  = INSTR_W / PARCEL_W;
  localparam int MAJ_W     = 5;

  localparam logic [MAJ_W-1:0] MAJ_COMPACT_MIN = 5'b01000;
  localparam logic [MAJ_W-1:0] MAJ_HREG        = 5'b01110;
  localparam logic [MAJ_W-1:0] MAJ_BREG_MIN    = 5'd2;
  localparam logic [MAJ_W-1:0] MAJ_LOAD        = 5'd2;
  localparam logic [MAJ_W-1:0] MAJ_STORE       = 5'd3;
  localparam logic [MAJ_W-1:0] MAJ_GENOP_MIN   = 5'd4;
  localparam logic [5:0]       REG_LIMM        = 6'd62;
  localparam logic [4:0]       HREG_LIMM       = 5'd30;

  typedef enum logic [1:0] {
    LEN16 = 2'd0,
    LEN32 = 2'd1,
    LEN48 = 2'd2,
    LEN64 = 2'd3
  } len_e;
endpackage

// File: rtl/ild_len_decode.sv
module ild_len_decode
  import ild_pkg::*;
(
  input  logic [PARCEL_W-1:0] p0_i,
  input  logic [PARCEL_W-1:0] p1_i,
  output len_e                len_o
);
  logic [MAJ_W-1:0] major;
  logic [4:0]       h_fld;
  logic [5:0]       b_fld;
  logic [5:0]       c_fld;
  logic [1:0]       fmt;
  logic             b_limm, c_is_reg, c_limm;
  logic             unused_bits;

  assign major = p0_i[15:11];
  assign h_fld = {p0_i[1:0], p0_i[7:5]};
  // 32-bit word W = {p0, p1}: W[26:24]=p0[10:8], W[14:12]=p1[14:12]
  assign b_fld = {p1_i[14:12], p0_i[10:8]};
  assign c_fld = p1_i[11:6];
  assign fmt   = p0_i[7:6];

  assign b_limm   = (major >= MAJ_BREG_MIN) && (b_fld == REG_LIMM);
  assign c_is_reg = (major == MAJ_STORE) ||
                    ((major >= MAJ_GENOP_MIN) && (fmt != 2'b01) && (fmt != 2'b10));
  assign c_limm   = c_is_reg && (c_fld == REG_LIMM);

  always_comb begin
    if (major >= MAJ_COMPACT_MIN) begin
      len_o = ((major == MAJ_HREG) && (h_fld == HREG_LIMM)) ? LEN48 : LEN16;
    end else begin
      len_o = (b_limm || c_limm) ? LEN64 : LEN32;
    end
  end

  assign unused_bits = ^{p1_i[15], p1_i[5:0], p0_i[4:2], (major == MAJ_LOAD)};
endmodule

// File: rtl/ild_parcel_buf.sv
module ild_parcel_buf
  import ild_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              flush_i,
  input  logic                              enq_i,
  input  logic [PARCEL_W-1:0]               enq_data_i,
  input  logic                              deq_i,
  input  logic [CNT_W-1:0]                  deq_n_i,
  output logic [MAX_PARC-1:0][PARCEL_W-1:0] head_o,
  output logic [CNT_W-1:0]                  cnt_o,
  output logic                              full_o
);
  logic [PARCEL_W-1:0] q_q [DEPTH];
  logic [PARCEL_W-1:0] q_d [DEPTH];
  logic [CNT_W-1:0]    cnt_q, cnt_d;

  always_comb begin
    int sh, rem, src;
    sh  = deq_i ? int'(deq_n_i) : 0;
    rem = int'(cnt_q) - sh;
    for (int i = 0; i < DEPTH; i++) begin
      src    = i + sh;
      q_d[i] = (src < DEPTH) ? q_q[src[IDX_W-1:0]] : '0;
      if (enq_i && (i == rem)) q_d[i] = enq_data_i;
    end
    cnt_d = CNT_W'(rem + (enq_i ? 1 : 0));
    if (flush_i) cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) q_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      for (int i = 0; i < DEPTH; i++) q_q[i] <= q_d[i];
    end
  end

  for (genvar k = 0; k < MAX_PARC; k++) begin : g_head
    assign head_o[k] = q_q[k];
  end

  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == CNT_W'(DEPTH));

  a_r10_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= DEPTH);
  a_r10_no_write_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !enq_i);
  a_r7_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deq_i |-> (deq_n_i <= cnt_q));
endmodule

// File: rtl/ild_align.sv
module ild_align
  import ild_pkg::*;
(
  input  logic [MAX_PARC-1:0][PARCEL_W-1:0] head_i,
  input  len_e                              len_i,
  output logic [INSTR_W-1:0]                instr_o
);
  for (genvar k = 0; k < MAX_PARC; k++) begin : g_slot
    assign instr_o[INSTR_W-1-k*PARCEL_W -: PARCEL_W] =
      (k <= int'(len_i)) ? head_i[k] : '0;
  end
endmodule

// File: rtl/instr_len_dec.sv
module instr_len_dec
  import ild_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flush_i,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [PARCEL_W-1:0] in_parcel_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [INSTR_W-1:0]  out_instr_o,
  output logic [1:0]          out_len_o
);
  logic [MAX_PARC-1:0][PARCEL_W-1:0] head;
  logic [CNT_W-1:0] cnt, need_n;
  logic             full, enq, deq;
  len_e             len;

  ild_parcel_buf #(.DEPTH(DEPTH)) i_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .enq_i      (enq),
    .enq_data_i (in_parcel_i),
    .deq_i      (deq),
    .deq_n_i    (need_n),
    .head_o     (head),
    .cnt_o      (cnt),
    .full_o     (full)
  );

  ild_len_decode i_dec (
    .p0_i  (head[0]),
    .p1_i  (head[1]),
    .len_o (len)
  );

  ild_align i_align (
    .head_i  (head),
    .len_i   (len),
    .instr_o (out_instr_o)
  );

  // a 32-bit major with one parcel decodes to >= 2 parcels, so no early valid
  assign need_n      = CNT_W'(int'(len) + 1);
  assign out_valid_o = !flush_i && (cnt >= need_n);
  assign out_len_o   = len;
  assign in_ready_o  = !flush_i && !full;
  assign enq         = in_valid_i && in_ready_o;
  assign deq         = out_valid_o && out_ready_i;

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i && !flush_i) |=>
      (flush_i || (out_valid_o && $stable(out_instr_o) && $stable(out_len_o))));
  a_r9_flush_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !out_valid_o);
  a_r2_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_len_o == LEN16) |-> (out_instr_o[47:0] == '0));
  a_r6_tail_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_len_o == LEN48) |-> (out_instr_o[15:0] == '0));
  a_r3_tail_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_len_o == LEN32) |-> (out_instr_o[31:0] == '0));
endmodule

// File: tb/test_instr_len_dec.sv
module test_instr_len_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready_o;
  logic [15:0] in_parcel = '0;
  logic        out_valid_o;
  logic        out_ready = 1'b0;
  logic [63:0] out_instr_o;
  logic [1:0]  out_len_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] stream [2048];
  int sp_wr = 0, sp_rd = 0;
  logic [63:0] exp_ins [512];
  logic [1:0]  exp_len [512];
  string       exp_req [512];
  int ew = 0, er = 0;

  logic        s_in_ready, s_out_valid, s_in_fire;
  logic [63:0] s_instr;

  always #10 clk = ~clk;

  instr_len_dec i_instr_len_dec (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .flush_i     (flush),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready_o),
    .in_parcel_i (in_parcel),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready),
    .out_instr_o (out_instr_o),
    .out_len_o   (out_len_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic make_instr(input int kind, output logic [63:0] ins,
                            output logic [1:0] len, output string req);
    logic [31:0] w, limm;
    logic [15:0] c16;
    logic [4:0]  mj, h;
    logic [5:0]  b;
    w = $urandom; limm = $urandom; c16 = 16'($urandom);
    b = 6'($urandom % 62);
    case (kind)
      0: begin
        mj = 5'(8 + $urandom % 24); h = 5'($urandom);
        if (mj == 5'd14 && h == 5'd30) h = 5'd3;
        c16[15:11] = mj; c16[7:5] = h[2:0]; c16[1:0] = h[4:3];
        ins = {c16, 48'h0}; len = 2'd0; req = "R2";
      end
      1: begin
        c16[15:11] = 5'b01110; c16[7:5] = 3'b110; c16[1:0] = 2'b11;
        ins = {c16, limm, 16'h0}; len = 2'd2; req = "R6";
      end
      2: begin
        w[31:27] = 5'($urandom % 2);
        ins = {w, 32'h0}; len = 2'd1; req = "R3";
      end
      3: begin
        w[31:27] = 5'(2 + $urandom % 6); b = 6'd62;
        w[26:24] = b[2:0]; w[14:12] = b[5:3];
        ins = {w, limm}; len = 2'd3; req = "R4";
      end
      4: begin
        w[31:27] = 5'(3 + $urandom % 5);
        w[26:24] = b[2:0]; w[14:12] = b[5:3]; w[11:6] = 6'd62;
        if (w[31:27] >= 5'd4) w[23:22] = ($urandom % 2 == 0) ? 2'b00 : 2'b11;
        ins = {w, limm}; len = 2'd3; req = "R5";
      end
      5: begin
        w[31:27] = 5'(4 + $urandom % 4);
        w[26:24] = b[2:0]; w[14:12] = b[5:3]; w[11:6] = 6'd62;
        w[23:22] = ($urandom % 2 == 0) ? 2'b01 : 2'b10;
        ins = {w, 32'h0}; len = 2'd1; req = "R5";
      end
      6: begin
        w[31:27] = 5'd2;
        w[26:24] = b[2:0]; w[14:12] = b[5:3]; w[11:6] = 6'd62;
        ins = {w, 32'h0}; len = 2'd1; req = "R5";
      end
      default: begin
        w[31:27] = 5'(2 + $urandom % 6);
        w[26:24] = b[2:0]; w[14:12] = b[5:3]; w[11:6] = 6'($urandom % 62);
        ins = {w, 32'h0}; len = 2'd1; req = "R3";
      end
    endcase
  endtask

  task automatic push_instr(input int kind);
    logic [63:0] ins; logic [1:0] len; string req;
    make_instr(kind, ins, len, req);
    for (int k = 0; k <= int'(len); k++) begin
      stream[sp_wr] = ins[63-16*k -: 16];
      sp_wr++;
    end
    exp_ins[ew] = ins; exp_len[ew] = len; exp_req[ew] = req; ew++;
  endtask

  task automatic step(input logic iv, input logic [15:0] ip, input logic ordy, input logic fl);
    @(negedge clk);
    in_valid = iv; in_parcel = ip; out_ready = ordy; flush = fl;
    #1;
    s_in_ready  = in_ready_o;
    s_out_valid = out_valid_o;
    s_instr     = out_instr_o;
    s_in_fire   = iv && in_ready_o;
    if (out_valid_o && ordy) begin
      checks++;
      if (er >= ew) begin
        failures++;
        $display("FAIL R7 unexpected output actual=%h expected=none", out_instr_o);
      end else begin
        if (out_instr_o !== exp_ins[er] || out_len_o !== exp_len[er]) begin
          failures++;
          $display("FAIL %s actual=%h/%0d expected=%h/%0d", exp_req[er],
                   out_instr_o, out_len_o, exp_ins[er], exp_len[er]);
        end
        er++;
      end
    end
  endtask

  task automatic feed_all(input logic ordy);
    while (sp_rd < sp_wr) begin
      step(1'b1, stream[sp_rd], ordy, 1'b0);
      if (s_in_fire) sp_rd++;
    end
  endtask

  task automatic drain();
    int guard = 0;
    while (er < ew && guard < 100) begin
      step(1'b0, 16'h0, 1'b1, 1'b0);
      guard++;
    end
    chk("R7", 64'(er), 64'(ew));
  endtask

  initial begin
    logic [63:0] held, ins; logic [1:0] len; string req;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    step(1'b0, 16'h0, 1'b0, 1'b0);
    chk("R1", 64'(s_out_valid), 64'd0);
    chk("R1", 64'(s_in_ready), 64'd1);

    // R7 no valid on a partial 64-bit instruction
    push_instr(3);
    for (int k = 0; k < 4; k++) begin
      step(1'b1, stream[sp_rd], 1'b1, 1'b0);
      chk("R7", 64'(s_out_valid), 64'd0);
      if (s_in_fire) sp_rd++;
    end
    drain();

    // R8 stall holds output
    push_instr(2);
    feed_all(1'b0);
    step(1'b0, 16'h0, 1'b0, 1'b0);
    chk("R8", 64'(s_out_valid), 64'd1);
    held = s_instr;
    repeat (3) begin
      step(1'b0, 16'h0, 1'b0, 1'b0);
      chk("R8", 64'(s_out_valid), 64'd1);
      chk("R8", s_instr, held);
    end
    drain();

    // R10 full buffer blocks input, order kept
    push_instr(7); push_instr(7); push_instr(0);
    for (int k = 0; k < 4; k++) begin
      step(1'b1, stream[sp_rd], 1'b0, 1'b0);
      if (s_in_fire) sp_rd++;
    end
    step(1'b1, stream[sp_rd], 1'b0, 1'b0);
    chk("R10", 64'(s_in_ready), 64'd0);
    feed_all(1'b1);
    drain();

    // R9 flush drops partial instruction and the parcel offered with it
    make_instr(3, ins, len, req);
    step(1'b1, ins[63:48], 1'b1, 1'b0);
    step(1'b1, ins[47:32], 1'b1, 1'b0);
    step(1'b1, 16'h4000, 1'b1, 1'b1);
    chk("R9", 64'(s_in_ready), 64'd0);
    step(1'b0, 16'h0, 1'b1, 1'b0);
    chk("R9", 64'(s_out_valid), 64'd0);
    push_instr(0);
    feed_all(1'b1);
    drain();

    // R9 flush suppresses a complete waiting instruction
    push_instr(0);
    step(1'b1, stream[sp_rd], 1'b0, 1'b0);
    sp_rd++;
    step(1'b0, 16'h0, 1'b1, 1'b1);
    chk("R9", 64'(s_out_valid), 64'd0);
    step(1'b0, 16'h0, 1'b1, 1'b0);
    chk("R9", 64'(s_out_valid), 64'd0);
    er = ew;

    // R2 R3 R4 R5 R6 random stream with random backpressure
    for (int n = 0; n < 240; n++) push_instr(int'($urandom % 8));
    while (sp_rd < sp_wr || er < ew) begin
      logic iv, ordy;
      iv   = (sp_rd < sp_wr) && ($urandom % 4 != 0);
      ordy = ($urandom % 10) < 7;
      step(iv, iv ? stream[sp_rd] : 16'h0, ordy, 1'b0);
      if (s_in_fire) sp_rd++;
    end
    step(1'b0, 16'h0, 1'b1, 1'b0);
    chk("R7", 64'(s_out_valid), 64'd0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule